// File: doc/BRIEF.md
# Debug Event Compare Unit

This unit observes a processor core's retirement and memory-access strobes and turns selected occurrences into debug events. Two instruction compare registers match against the address of each retired instruction. Two data compare registers match against load and store addresses, and each can be armed for loads, for stores, or for both. Three trace events are also detected: any retired instruction, a taken branch, and a taken interrupt.

Every event source has its own enable bit in a control register, and a master enable gates all of them. An event that is recognised sets a sticky bit in a status register. Software clears status bits by writing ones to them. The debug interrupt request stays asserted for as long as any status bit is set. Software programs the control, status and compare registers through a simple single-cycle register port. Reads of that port are combinational.

Top module: `dbg_evt_unit`

## Requirements
- R1: An instruction compare hit posts its status bit (status bit 3 for compare 0, bit 4 for compare 1). A hit needs `ret_valid_i` high, `ret_pc_i` equal to the compare register, and the compare's control enable set (control bit 4 for compare 0, bit 5 for compare 1). A retired address that differs from the register posts nothing.
- R2: A data compare hit needs `mem_valid_i` high and `mem_addr_i` equal to the compare register. A load (`mem_store_i`=0) is qualified by the compare's read enable, and a store (`mem_store_i`=1) by its write enable. Data compare 0 uses control bits 6 (read) and 7 (write) and posts status bit 5. Data compare 1 uses control bits 8 (read) and 9 (write) and posts status bit 6.
- R3: Control bit 0 is the master enable. While it is clear, no status bit becomes set, whatever the other enables and inputs are.
- R4: Three trace events post their own status bits when their control enables are set. A retired instruction uses control bit 1 and posts status bit 0. A taken branch (`br_taken_i`) uses control bit 2 and posts status bit 1. A taken interrupt (`irq_taken_i`) uses control bit 3 and posts status bit 2.
- R5: Status bits are sticky. Writing to the status register clears exactly the bits written as 1, and writing 0 to a bit has no effect on it. If a bit is posted in the same cycle that a write clears it, the bit ends up set.
- R6: `dbg_irq_o` is high exactly while at least one status bit is set. It goes high in the cycle after an event is posted.
- R7: After reset, the control, status and compare registers are all zero and `dbg_irq_o` is low.
- R8: The register port uses these word offsets: 0 control, 1 status, 2 and 3 instruction compares 0 and 1, 4 and 5 data compares 0 and 1. A write takes effect at the next clock edge. `reg_rdata_o` shows the addressed register combinationally, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW (3) | Register word offset |
| reg_wdata_i | input | AW (32) | Register write data |
| reg_rdata_o | output | AW (32) | Read data of the addressed register |
| ret_valid_i | input | 1 | An instruction retired this cycle |
| ret_pc_i | input | AW (32) | Address of the retired instruction |
| br_taken_i | input | 1 | A branch was taken this cycle |
| irq_taken_i | input | 1 | An interrupt was taken this cycle |
| mem_valid_i | input | 1 | A data access happened this cycle |
| mem_store_i | input | 1 | The access is a store (1) or a load (0) |
| mem_addr_i | input | AW (32) | Data access address |
| dbg_irq_o | output | 1 | Debug interrupt request |

## Verification
Some rules are checked by assertions on every cycle. Status bits stay set until a write clears them, and a posting wins over a same-cycle clear. Nothing posts while the master enable is clear. The request rises after any posting. A rising compare bit must have been caused by a matching, qualified access in the cycle before. Only the bench scenarios can show the absence of a post in other cases: a mismatching address, a load against a store-only compare, or a trace source that is not enabled. The bench also covers partial clears, the combined posting of several sources in one cycle, and the register readback.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_STAT     = 1;
  localparam int unsigned REG_CMP_BASE = 2;
  // trace event positions (control bit = position + 1)
  localparam int unsigned TR_RETIRE = 0;
  localparam int unsigned TR_BRANCH = 1;
  localparam int unsigned TR_IRQ    = 2;
  localparam int unsigned TR_N      = 3;
  localparam int unsigned CTRL_MASTER = 0;
endpackage

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] cmp_i,
  output logic          hit_o
);
  assign hit_o = en_i & valid_i & (addr_i == cmp_i);
endmodule

// File: rtl/dbg_sticky_status.sv
module dbg_sticky_status #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(clr_i)) & ~status_q) == '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R5
  AST_IRQ_AFTER_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> irq_o); // R6
endmodule

// File: rtl/dbg_evt_unit.sv
module dbg_evt_unit
  import dbg_evt_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NIAC = 2,
  parameter int unsigned NDAC = 2,
  localparam int unsigned RAW = $clog2(2 + NIAC + NDAC)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic [AW-1:0]  reg_rdata_o,
  input  logic           ret_valid_i,
  input  logic [AW-1:0]  ret_pc_i,
  input  logic           br_taken_i,
  input  logic           irq_taken_i,
  input  logic           mem_valid_i,
  input  logic           mem_store_i,
  input  logic [AW-1:0]  mem_addr_i,
  output logic           dbg_irq_o
);
  localparam int unsigned CW        = 1 + TR_N + NIAC + 2 * NDAC;
  localparam int unsigned SW        = TR_N + NIAC + NDAC;
  localparam int unsigned C_IAC     = 1 + TR_N;
  localparam int unsigned C_DAC     = C_IAC + NIAC;
  localparam int unsigned S_IAC     = TR_N;
  localparam int unsigned S_DAC     = TR_N + NIAC;
  localparam int unsigned A_DAC     = REG_CMP_BASE + NIAC;

  logic [CW-1:0] ctrl_q;
  logic [AW-1:0] iac_q [NIAC];
  logic [AW-1:0] dac_q [NDAC];
  logic [SW-1:0] evt, set_vec, clr_vec, status;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      for (int i = 0; i < NIAC; i++) iac_q[i] <= '0;
      for (int i = 0; i < NDAC; i++) dac_q[i] <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == RAW'(REG_CTRL)) ctrl_q <= reg_wdata_i[CW-1:0];
      for (int i = 0; i < NIAC; i++)
        if (reg_addr_i == RAW'(REG_CMP_BASE + i)) iac_q[i] <= reg_wdata_i;
      for (int i = 0; i < NDAC; i++)
        if (reg_addr_i == RAW'(A_DAC + i)) dac_q[i] <= reg_wdata_i;
    end
  end

  // trace events
  assign evt[TR_RETIRE] = ctrl_q[TR_RETIRE + 1] & ret_valid_i;
  assign evt[TR_BRANCH] = ctrl_q[TR_BRANCH + 1] & br_taken_i;
  assign evt[TR_IRQ]    = ctrl_q[TR_IRQ + 1]    & irq_taken_i;

  for (genvar g = 0; g < NIAC; g++) begin : g_iac
    dbg_addr_cmp #(.AW(AW)) u_cmp (
      .en_i   (ctrl_q[C_IAC + g]),
      .valid_i(ret_valid_i),
      .addr_i (ret_pc_i),
      .cmp_i  (iac_q[g]),
      .hit_o  (evt[S_IAC + g])
    );
  end

  for (genvar g = 0; g < NDAC; g++) begin : g_dac
    logic dir_en;
    // read enable at even offset, write enable at odd
    assign dir_en = mem_store_i ? ctrl_q[C_DAC + 2*g + 1] : ctrl_q[C_DAC + 2*g];
    dbg_addr_cmp #(.AW(AW)) u_cmp (
      .en_i   (dir_en),
      .valid_i(mem_valid_i),
      .addr_i (mem_addr_i),
      .cmp_i  (dac_q[g]),
      .hit_o  (evt[S_DAC + g])
    );
  end

  assign set_vec = evt & {SW{ctrl_q[CTRL_MASTER]}};
  assign clr_vec = (reg_we_i && reg_addr_i == RAW'(REG_STAT)) ? reg_wdata_i[SW-1:0] : '0;

  dbg_sticky_status #(.N(SW)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .status_o(status),
    .irq_o   (dbg_irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == RAW'(REG_CTRL)) reg_rdata_o[CW-1:0] = ctrl_q;
    if (reg_addr_i == RAW'(REG_STAT)) reg_rdata_o[SW-1:0] = status;
    for (int i = 0; i < NIAC; i++)
      if (reg_addr_i == RAW'(REG_CMP_BASE + i)) reg_rdata_o = iac_q[i];
    for (int i = 0; i < NDAC; i++)
      if (reg_addr_i == RAW'(A_DAC + i)) reg_rdata_o = dac_q[i];
  end

  AST_MASTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CTRL_MASTER] |=> ((status & ~$past(status)) == '0)); // R3
  AST_IAC0_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[S_IAC]) |-> ($past(ret_valid_i) && $past(ret_pc_i) == $past(iac_q[0]) && $past(ctrl_q[C_IAC]))); // R1
  AST_DAC0_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[S_DAC]) |-> ($past(mem_valid_i) && $past(mem_addr_i) == $past(dac_q[0]) &&
      ($past(mem_store_i) ? $past(ctrl_q[C_DAC + 1]) : $past(ctrl_q[C_DAC])))); // R2
  AST_TRACE_BR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[TR_BRANCH]) |-> ($past(br_taken_i) && $past(ctrl_q[TR_BRANCH + 1]))); // R4
endmodule

// File: tb/dbg_evt_unit_tb.sv
module dbg_evt_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic [9:0]  ctrl;
    logic        ret;
    logic [31:0] pc;
    logic        br;
    logic        it;
    logic        mv;
    logic        st;
    logic [31:0] ma;
    logic [6:0]  exp;
  } vec_t;

  // status bits: 0 retire,1 branch,2 irq,3 iac0,4 iac1,5 dac0,6 dac1
  localparam vec_t VECS [NV] = '{
    '{10'h3FF, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    7'h09}, // R1 R4
    '{10'h3FE, 1'b1, 32'h1000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h3000, 7'h00}, // R3
    '{10'h011, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    7'h00}, // R1 mismatch
    '{10'h021, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,    7'h10}, // R1
    '{10'h041, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 32'h3000, 7'h20}, // R2 load
    '{10'h041, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b1, 32'h3000, 7'h00}, // R2 store not armed
    '{10'h081, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b1, 32'h3000, 7'h20}, // R2 store
    '{10'h201, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b1, 32'h4000, 7'h40}, // R2
    '{10'h201, 1'b0, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 32'h4000, 7'h00}, // R2 load not armed
    '{10'h005, 1'b1, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,    7'h02}, // R4
    '{10'h009, 1'b0, 32'h0,    1'b0, 1'b1, 1'b0, 1'b0, 32'h0,    7'h04}, // R4
    '{10'h00F, 1'b1, 32'h5555, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,    7'h07}, // R4
    '{10'h3F1, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4000, 7'h48}  // R1 R2
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ret_valid = 1'b0, br_taken = 1'b0, irq_taken = 1'b0;
  logic        mem_valid = 1'b0, mem_store = 1'b0;
  logic [31:0] ret_pc = '0, mem_addr = '0;
  logic        dbg_irq;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_evt_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ret_valid_i(ret_valid),
    .ret_pc_i(ret_pc), .br_taken_i(br_taken), .irq_taken_i(irq_taken),
    .mem_valid_i(mem_valid), .mem_store_i(mem_store), .mem_addr_i(mem_addr),
    .dbg_irq_o(dbg_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle_inputs();
    ret_valid = 0; br_taken = 0; irq_taken = 0; mem_valid = 0; mem_store = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R7 reset state
    rd(3'd0, d); chk("R7 ctrl", d, 32'h0);
    rd(3'd1, d); chk("R7 status", d, 32'h0);
    rd(3'd2, d); chk("R7 iac0", d, 32'h0);
    chk("R7 irq", {31'b0, dbg_irq}, 32'h0);
    rst_ni = 1'b1;

    wr(3'd2, 32'h1000); wr(3'd3, 32'h2000);
    wr(3'd4, 32'h3000); wr(3'd5, 32'h4000);
    rd(3'd3, d); chk("R8 iac1 readback", d, 32'h2000);
    rd(3'd4, d); chk("R8 dac0 readback", d, 32'h3000);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {22'b0, VECS[i].ctrl});
      wr(3'd1, 32'h7F);
      ret_valid = VECS[i].ret; ret_pc = VECS[i].pc; br_taken = VECS[i].br;
      irq_taken = VECS[i].it; mem_valid = VECS[i].mv; mem_store = VECS[i].st;
      mem_addr = VECS[i].ma;
      @(negedge clk);
      idle_inputs();
      rd(3'd1, d);
      chk($sformatf("R1/R2/R3/R4 vector %0d status", i), d, {25'b0, VECS[i].exp});
      chk($sformatf("R6 vector %0d irq", i), {31'b0, dbg_irq}, {31'b0, VECS[i].exp != 0});
    end

    // R5 set wins over same-cycle clear
    wr(3'd0, 32'h013);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h7F;
    ret_valid = 1; ret_pc = 32'h1000;
    @(negedge clk);
    reg_we = 0; idle_inputs();
    rd(3'd1, d); chk("R5 set wins", d, 32'h09);
    // R5 sticky
    repeat (5) @(negedge clk);
    rd(3'd1, d); chk("R5 sticky", d, 32'h09);
    chk("R6 irq held", {31'b0, dbg_irq}, 32'h1);
    wr(3'd1, 32'h01);
    rd(3'd1, d); chk("R5 partial clear", d, 32'h08);
    chk("R6 irq still high", {31'b0, dbg_irq}, 32'h1);
    wr(3'd1, 32'h00);
    rd(3'd1, d); chk("R5 zero write", d, 32'h08);
    wr(3'd1, 32'h08);
    rd(3'd1, d); chk("R5 full clear", d, 32'h0);
    chk("R6 irq low", {31'b0, dbg_irq}, 32'h0);
    rd(3'd0, d); chk("R8 ctrl readback", d, 32'h013);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule